// File: doc/BRIEF.md
# Maintenance Command Mailbox

This block gives a host register bus a way to hand single maintenance commands to the upkeep logic of a memory controller. Software first fills one or more parameter registers, then writes a 32-bit request word. That write is the only thing that starts a command. The block splits the word into target type, target instance, command class and opcode. It checks the target fields against the values configured for this controller, then sends a one-cycle strobe downstream. The strobe carries the decoded fields and a snapshot of the parameter registers. Two commands matter here. Class 0x04 with opcode 0x109 injects an ECC error, taking its check-bit XOR mask from parameter 0. Class 0x04 with opcode 0x110 clears the error log and takes no parameters.

Completion is reported through a sticky ready flag in a status register. Software polls that flag and then clears it by writing the status word back with bit 0 at zero. A request aimed at another target never reaches the agent: it completes at once with an error code. A request written while a command is still outstanding is dropped, and a sticky overrun flag is raised instead.

The control is a three-state machine:
- `ST_IDLE`: waiting for a request.
- `ST_ISSUE`: the strobe cycle.
- `ST_WAIT`: waiting for the agent to finish.

Its transitions are:
- `ST_IDLE` to `ST_ISSUE`, on an accepted request.
- `ST_ISSUE` to `ST_WAIT`, unconditionally after one cycle.
- `ST_WAIT` to `ST_IDLE`, when the agent signals done.

A rejected request leaves the machine in `ST_IDLE`.

Top module: `mbx_cmd_mailbox`

## Requirements
- R1: After reset, the status word reads 0, busy and cmd_valid are 0, and every parameter register reads 0.
- R2: A write to offset 0x43C, made in `ST_IDLE` with bits [31:29] equal to LOCAL_TGT_TYPE (default 1) and bits [28:24] equal to LOCAL_TGT_INST (default 0), drives cmd_valid high for exactly the one cycle after the write. During that cycle cmd_tgt_type, cmd_tgt_inst, cmd_type and cmd_opcode show bits [31:29], [28:24], [23:16] and [15:0] of the written word.
- R3: Parameter register i sits at offset 0x438 minus 4*i. cmd_param carries the values those registers held when the request was accepted, and it holds them unchanged until the next accepted request, even if a parameter register is written in the meantime.
- R4: busy is 1 from the cycle after an accepted request until the cycle after agent_done is seen in `ST_WAIT`.
- R5: Completion by the agent sets status bit 0 (ready) and loads status bits [31:24] with agent_code.
- R6: Writing the status register at offset 0x45C with bit 0 at 0 clears ready. Writing 1 to bit 0 never sets ready and leaves it unchanged.
- R7: A request whose target type or instance does not match the configured values produces no strobe and leaves busy at 0. In the next cycle it shows ready at 1 and status bits [31:24] at 0xE1.
- R8: A request written while busy is ignored: no strobe, and the command outputs are unchanged. It sets the sticky overrun flag in status bit 1, which only a status write with bit 1 at 0 clears.
- R9: When hardware completion and a software clear of ready fall in the same cycle, ready ends up 1.
- R10: agent_done outside `ST_WAIT` has no effect on the state, on busy or on ready.
- R11: Reads at offset 0x43C return the last request word that was not ignored. Reads of a parameter offset return that register. Status bit 2 reads busy. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Write offset |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 32 | Combinational read data |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_tgt_type | output | 3 | Decoded target type |
| cmd_tgt_inst | output | 5 | Decoded target instance |
| cmd_type | output | 8 | Decoded command class |
| cmd_opcode | output | 16 | Decoded opcode |
| cmd_param | output | 32*NUM_PARAM | Parameter snapshot taken at acceptance |
| agent_done | input | 1 | Agent completion pulse |
| agent_code | input | 8 | Agent result code |
| busy | output | 1 | A command is outstanding |

## Verification
Two events can land in the same cycle and fight over the ready bit. One is hardware completion setting it. The other is a software write-back clearing it after an earlier command. The bench leaves ready set from one command and launches a second one. In the very cycle the agent reports done, it also drives a status write with bit 0 at zero. The run passes only if ready reads 1 and the status code belongs to the new command.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } mbx_state_e;

    typedef struct packed {
        logic [2:0]  tgt_type;
        logic [4:0]  tgt_inst;
        logic [7:0]  ctype;
        logic [15:0] opcode;
    } mbx_req_t;

    localparam logic [7:0] CODE_BAD_TARGET = 8'hE1;

endpackage

// File: rtl/mbx_param_regs.sv
module mbx_param_regs #(
    parameter int          ADDR_W     = 12,
    parameter int          NUM_PARAM  = 2,
    parameter int unsigned PARAM0_OFF = 'h438
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [NUM_PARAM*32-1:0] param_flat
);
    for (genvar gi = 0; gi < NUM_PARAM; gi++) begin : g_param
        localparam int unsigned OFF = PARAM0_OFF - 4 * gi;
        logic [31:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (reg_wr && reg_addr == OFF[ADDR_W-1:0]) begin
                val_q <= reg_wdata;
            end
        end
        assign param_flat[gi*32 +: 32] = val_q;
    end
endmodule

// File: rtl/mbx_fsm.sv
module mbx_fsm
    import mbx_pkg::*;
#(
    parameter logic [2:0] LOCAL_TGT_TYPE = 3'd1,
    parameter logic [4:0] LOCAL_TGT_INST = 5'd0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_wr,
    input  mbx_req_t req_word,
    input  logic     agent_done,
    output logic     accept,
    output logic     reject,
    output logic     overrun_evt,
    output logic     complete,
    output logic     cmd_valid,
    output logic     busy
);
    mbx_state_e state_q, state_d;
    logic       target_ok;

    assign target_ok = (req_word.tgt_type == LOCAL_TGT_TYPE) &&
                       (req_word.tgt_inst == LOCAL_TGT_INST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_wr && target_ok) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (agent_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept      = 1'b0;
        reject      = 1'b0;
        overrun_evt = 1'b0;
        complete    = 1'b0;
        cmd_valid   = 1'b0;
        busy        = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = req_wr && target_ok;
                reject = req_wr && !target_ok;
            end
            ST_ISSUE: begin
                cmd_valid   = 1'b1;
                overrun_evt = req_wr;
            end
            ST_WAIT: begin
                complete    = agent_done;
                overrun_evt = req_wr;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbx_status.sv
module mbx_status
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stat_wr,
    input  logic [31:0] stat_wdata,
    input  logic        complete,
    input  logic [7:0]  agent_code,
    input  logic        reject,
    input  logic        overrun_evt,
    input  logic        busy,
    output logic        rdy,
    output logic        ovr,
    output logic [31:0] status_word
);
    logic [7:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy    <= 1'b0;
            ovr    <= 1'b0;
            code_q <= '0;
        end else begin
            // hardware set takes priority over software clear
            if (complete || reject) begin
                rdy <= 1'b1;
            end else if (stat_wr) begin
                rdy <= rdy & stat_wdata[0];
            end
            if (overrun_evt) begin
                ovr <= 1'b1;
            end else if (stat_wr) begin
                ovr <= ovr & stat_wdata[1];
            end
            if (complete) begin
                code_q <= agent_code;
            end else if (reject) begin
                code_q <= CODE_BAD_TARGET;
            end
        end
    end

    assign status_word = {code_q, 21'd0, busy, ovr, rdy};
endmodule

// File: rtl/mbx_cmd_mailbox.sv
module mbx_cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int          ADDR_W         = 12,
    parameter int          NUM_PARAM      = 2,
    parameter int unsigned PARAM0_OFF     = 'h438,
    parameter int unsigned REQ_OFF        = 'h43C,
    parameter int unsigned STAT_OFF       = 'h45C,
    parameter logic [2:0]  LOCAL_TGT_TYPE = 3'd1,
    parameter logic [4:0]  LOCAL_TGT_INST = 5'd0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [31:0]             rd_data,
    output logic                    cmd_valid,
    output logic [2:0]              cmd_tgt_type,
    output logic [4:0]              cmd_tgt_inst,
    output logic [7:0]              cmd_type,
    output logic [15:0]             cmd_opcode,
    output logic [NUM_PARAM*32-1:0] cmd_param,
    input  logic                    agent_done,
    input  logic [7:0]              agent_code,
    output logic                    busy
);
    localparam int PW = NUM_PARAM * 32;

    logic          req_wr, stat_wr;
    logic          accept, reject, overrun_evt, complete;
    logic          stat_rdy, stat_ovr;
    logic [31:0]   status_word;
    logic [PW-1:0] param_flat, param_q;
    mbx_req_t      req_q;

    assign req_wr  = reg_wr && (reg_addr == REQ_OFF[ADDR_W-1:0]);
    assign stat_wr = reg_wr && (reg_addr == STAT_OFF[ADDR_W-1:0]);

    mbx_param_regs #(
        .ADDR_W(ADDR_W), .NUM_PARAM(NUM_PARAM), .PARAM0_OFF(PARAM0_OFF)
    ) params_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .param_flat(param_flat)
    );

    mbx_fsm #(
        .LOCAL_TGT_TYPE(LOCAL_TGT_TYPE), .LOCAL_TGT_INST(LOCAL_TGT_INST)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_word(mbx_req_t'(reg_wdata)),
        .agent_done(agent_done), .accept(accept), .reject(reject),
        .overrun_evt(overrun_evt), .complete(complete),
        .cmd_valid(cmd_valid), .busy(busy)
    );

    mbx_status status_i (
        .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .stat_wdata(reg_wdata),
        .complete(complete), .agent_code(agent_code), .reject(reject),
        .overrun_evt(overrun_evt), .busy(busy), .rdy(stat_rdy), .ovr(stat_ovr),
        .status_word(status_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= '0;
            param_q <= '0;
        end else begin
            if (accept || reject) begin
                req_q <= mbx_req_t'(reg_wdata);
            end
            if (accept) begin
                param_q <= param_flat;
            end
        end
    end

    assign cmd_tgt_type = req_q.tgt_type;
    assign cmd_tgt_inst = req_q.tgt_inst;
    assign cmd_type     = req_q.ctype;
    assign cmd_opcode   = req_q.opcode;
    assign cmd_param    = param_q;

    always_comb begin
        rd_data = '0;
        if (rd_addr == REQ_OFF[ADDR_W-1:0]) begin
            rd_data = req_q;
        end else if (rd_addr == STAT_OFF[ADDR_W-1:0]) begin
            rd_data = status_word;
        end
        for (int i = 0; i < NUM_PARAM; i++) begin
            if (rd_addr == ADDR_W'(PARAM0_OFF - 4 * i)) begin
                rd_data = param_flat[i*32 +: 32];
            end
        end
    end
endmodule

// File: rtl/mbx_cmd_mailbox_chk.sv
module mbx_cmd_mailbox_chk #(
    parameter int          ADDR_W         = 12,
    parameter int          NUM_PARAM      = 2,
    parameter int unsigned REQ_OFF        = 'h43C,
    parameter logic [2:0]  LOCAL_TGT_TYPE = 3'd1,
    parameter logic [4:0]  LOCAL_TGT_INST = 5'd0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_wr,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic [31:0]             reg_wdata,
    input logic                    agent_done,
    input logic                    cmd_valid,
    input logic                    busy,
    input logic [NUM_PARAM*32-1:0] cmd_param,
    input logic                    rdy,
    input logic                    ovr
);
    logic req_hit, tgt_match;
    assign req_hit   = reg_wr && reg_addr == REQ_OFF[ADDR_W-1:0];
    assign tgt_match = reg_wdata[31:29] == LOCAL_TGT_TYPE &&
                       reg_wdata[28:24] == LOCAL_TGT_INST;

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r2_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit && !busy && tgt_match |=> cmd_valid);

    a_r3_params_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cmd_valid |-> $stable(cmd_param));

    a_r4_strobe_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    a_r6_ready_only_by_hw: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy && !(agent_done && busy) && !req_hit |=> !rdy);

    a_r7_reject_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit && !busy && !tgt_match |=> !cmd_valid && !busy && rdy);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit && busy |=> ovr && !cmd_valid);
endmodule

bind mbx_cmd_mailbox mbx_cmd_mailbox_chk #(
    .ADDR_W(ADDR_W), .NUM_PARAM(NUM_PARAM), .REQ_OFF(REQ_OFF),
    .LOCAL_TGT_TYPE(LOCAL_TGT_TYPE), .LOCAL_TGT_INST(LOCAL_TGT_INST)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .agent_done(agent_done), .cmd_valid(cmd_valid),
    .busy(busy), .cmd_param(cmd_param), .rdy(stat_rdy), .ovr(stat_ovr)
);

// File: tb/mbx_cmd_mailbox_tb.sv
module mbx_cmd_mailbox_tb_top;
    localparam logic [11:0] P0 = 12'h438, P1 = 12'h434, RQ = 12'h43C, ST = 12'h45C;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0, rd_addr = '0;
    logic [31:0] reg_wdata = '0, rd_data;
    logic        cmd_valid, busy, agent_done = 1'b0;
    logic [2:0]  cmd_tgt_type;
    logic [4:0]  cmd_tgt_inst;
    logic [7:0]  cmd_type, agent_code = '0;
    logic [15:0] cmd_opcode;
    logic [63:0] cmd_param;

    int checks = 0, errors = 0;
    logic       m_rdy = 0, m_ovr = 0;
    logic [7:0] m_code = 0;

    always #5 clk = ~clk;

    mbx_cmd_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_tgt_type(cmd_tgt_type), .cmd_tgt_inst(cmd_tgt_inst),
        .cmd_type(cmd_type), .cmd_opcode(cmd_opcode), .cmd_param(cmd_param),
        .agent_done(agent_done), .agent_code(agent_code), .busy(busy)
    );

    function automatic logic [31:0] exp_status(logic r, logic o, logic b, logic [7:0] c);
        return {c, 21'd0, b, o, r};
    endfunction

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic finish_cmd(logic [7:0] code, int lat);
        repeat (1 + lat) @(negedge clk);
        agent_done = 1'b1; agent_code = code;
        @(negedge clk);
        agent_done = 1'b0;
        m_rdy = 1; m_code = code;
    endtask

    task automatic clear_ready();
        logic [31:0] v;
        rd(ST, v);
        wr(ST, v & 32'hFFFF_FFFE);
        m_rdy = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(ST, v); chk("R1 status", v, 0);
        chk("R1 busy/valid", {busy, cmd_valid}, 0);
        rd(P0, v); chk("R1 param0", v, 0);

        // R2/R3 injection command
        wr(P0, 32'hF4);
        wr(P1, 32'hA5A5_0001);
        wr(RQ, 32'h2004_0109);
        chk("R2 strobe", cmd_valid, 1);
        chk("R2 fields", {cmd_tgt_type, cmd_tgt_inst, cmd_type, cmd_opcode}, 32'h2004_0109);
        chk("R3 params", cmd_param, {32'hA5A5_0001, 32'hF4});
        @(negedge clk);
        chk("R2 strobe one cycle", cmd_valid, 0);
        chk("R4 busy", busy, 1);
        wr(P0, 32'h55);
        chk("R3 params held", cmd_param[31:0], 32'hF4);
        finish_cmd(8'h00, 2);
        chk("R4 busy released", busy, 0);
        rd(ST, v); chk("R5 status", v, exp_status(1, 0, 0, 8'h00));

        // R6 write one leaves ready, write zero clears, write one does not set
        wr(ST, 32'hFFFF_FFFF);
        rd(ST, v); chk("R6 write1 keeps", v, exp_status(1, 0, 0, 8'h00));
        clear_ready();
        rd(ST, v); chk("R6 cleared", v, 0);
        wr(ST, 32'h1);
        rd(ST, v); chk("R6 write1 no set", v, 0);

        // R7 target mismatch
        wr(RQ, 32'h4004_0110);
        chk("R7 no strobe", {cmd_valid, busy}, 0);
        rd(ST, v); chk("R7 status", v, exp_status(1, 0, 0, 8'hE1));
        clear_ready();
        wr(RQ, 32'h2104_0110);
        chk("R7 inst mismatch", cmd_valid, 0);
        rd(ST, v); chk("R7 inst status", v[31:24], 8'hE1);
        clear_ready();

        // R8 overrun
        wr(RQ, 32'h2004_0110);
        wr(RQ, 32'h2004_1234);
        chk("R8 no strobe", cmd_valid, 0);
        chk("R8 opcode kept", cmd_opcode, 16'h0110);
        rd(ST, v); chk("R8 overrun", v, exp_status(0, 1, 1, 8'hE1));
        finish_cmd(8'h00, 0);
        wr(ST, 32'hFFFF_FFFD);
        rd(ST, v); chk("R8 overrun cleared", v, exp_status(1, 0, 0, 8'h00));
        clear_ready();

        // R10 done during issue cycle ignored
        wr(RQ, 32'h2004_0110);
        agent_done = 1'b1; agent_code = 8'h77;
        @(negedge clk);
        agent_done = 1'b0;
        chk("R10 still busy", busy, 1);
        rd(ST, v); chk("R10 ready low", v, exp_status(0, 0, 1, 8'h00));
        finish_cmd(8'h00, 0);
        // ready left set on purpose for R9

        // R9 completion beats clear in same cycle
        wr(RQ, 32'h2004_0109);
        @(negedge clk);
        agent_done = 1'b1; agent_code = 8'h3C;
        reg_wr = 1'b1; reg_addr = ST; reg_wdata = 32'h0;
        @(negedge clk);
        agent_done = 1'b0; reg_wr = 1'b0;
        rd(ST, v); chk("R9 set wins", v, exp_status(1, 0, 0, 8'h3C));
        clear_ready();

        // R11 readback
        rd(P0, v); chk("R11 param0", v, 32'h55);
        rd(P1, v); chk("R11 param1", v, 32'hA5A5_0001);
        rd(RQ, v); chk("R11 request", v, 32'h2004_0109);
        rd(12'h100, v); chk("R11 unmapped", v, 0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [31:0] w, p0, p1;
            logic [7:0] code;
            logic hit;
            hit = ($urandom % 5) != 0;
            w = {hit ? 3'd1 : 3'(2 + $urandom % 6), hit ? 5'd0 : 5'($urandom),
                 8'($urandom), 16'($urandom)};
            p0 = $urandom; p1 = $urandom; code = 8'($urandom);
            wr(P0, p0); wr(P1, p1);
            wr(RQ, w);
            if (hit) begin
                chk("R2 rand strobe", cmd_valid, 1);
                chk("R2 rand fields", {cmd_tgt_type, cmd_tgt_inst, cmd_type, cmd_opcode}, w);
                chk("R3 rand params", cmd_param, {p1, p0});
                finish_cmd(code, $urandom % 5);
            end else begin
                chk("R7 rand no strobe", cmd_valid, 0);
                m_rdy = 1; m_code = 8'hE1;
            end
            rd(ST, v); chk("R5 rand status", v, exp_status(m_rdy, m_ovr, 0, m_code));
            clear_ready();
        end
        summary();
    end
endmodule